// File: doc/BRIEF.md
# Power-Domain Switch Sequencer

This block steps a switchable power domain between its collapsed and powered states through a fixed hardware sequence. To power up, it closes a small group of head switches first, which limits inrush current. It waits, then closes the remaining switches and waits again. It then holds the domain clocks gated for a short fixed interval before releasing them. To collapse the domain, it gates the clocks first, waits, and then opens all switches. Each programmable wait is a power-of-two count of pulses on a reference-clock tick input. Each wait exponent has its own 4-bit field in the control word.

Software drives the block through a small synchronous register port. It requests collapse or restore with one control bit. It can also hand the request over to an external trigger pin by setting a hardware-control bit. A software-override bit skips all waits, so each step lasts one clock. The reported power-on status bit lags every accepted request by a fixed number of reference ticks. This matches the start-up latency of the sequencer, so a read straight after a request never shows the new state early. A second word carries power-up and power-down completion flags and a flop-retention enable.

Top module: `pwr_switch_seq`

## Requirements
- R1: After reset the domain is collapsed, with both switch groups open and clocks gated. The control word (byte address 0x0) reads 0x00282001: wait exponents 2 in bits 23:20 (rest), 8 in bits 19:16 (few), 2 in bits 15:12 (clock-disable), and the collapse bit 0 set. The config word (byte address 0x4) reads 0x00008000.
- R2: Control bits 23:12, 2, 1 and 0 are writable. Bit 31 of the control word and bits 16 and 15 of the config word ignore writes. Config bit 11 is writable and drives `retain_en`. Reads return the addressed word one clock after the address is presented.
- R3: A restore (effective request low in the collapsed state) closes the few-switch group on the next clock. That group holds alone for 2^few ticks. The remaining switches then close and hold for 2^rest ticks. Clocks stay gated for HOLD_CYC further clocks, after which `clk_en` rises.
- R4: A collapse request (effective request high in the powered state) drops `clk_en` on the next clock. The switches stay closed for 2^clkdis ticks and then both groups open together.
- R5: Wait intervals advance only on clocks where `ref_tick` is high, so a sparse tick stretches the sequence in proportion.
- R6: With the software-override bit (control bit 2) set, each sequence step lasts exactly one clock, whatever the wait fields hold.
- R7: With hardware control (control bit 1) set, `hw_trig` high requests collapse and low requests restore, and the collapse bit has no effect.
- R8: Control bit 31 (power-on status) keeps its previous value from the clock a request is accepted until LAG_TICKS reference ticks have passed. It then follows whether the domain is fully powered.
- R9: Config bit 16 is 1 exactly when the domain is fully powered. Config bit 15 is 1 exactly when it is fully collapsed.
- R10: A request change during a sequence does not interrupt it. It is acted on only once the domain reaches the fully powered or fully collapsed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse per reference-clock period |
| hw_trig | input | 1 | Collapse request when hardware control is on (1 = collapse) |
| addr | input | 4 | Byte address: 0x0 control, 0x4 config |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sw_few_en | output | 1 | Close the first, small switch group |
| sw_rest_en | output | 1 | Close the remaining switch group |
| clk_en | output | 1 | Release the domain clocks |
| retain_en | output | 1 | Flop-retention enable |

## Verification
The assertions assume that the wait fields are not rewritten while a wait is running. The count limit is recomputed each clock, so a mid-wait change would move the end point. The stimulus only changes wait fields while the domain sits fully on or fully off. The assertions also assume that `ref_tick` and `hw_trig` are synchronous to `clk`. The bench drives every input on the falling edge, so both hold for the whole cycle the sequencer samples them.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power-domain switch sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_FEW    = 3'd1,
        S_REST   = 3'd2,
        S_HOLD   = 3'd3,
        S_ON     = 3'd4,
        S_CLKOFF = 3'd5
    } seq_state_e;

    localparam int WAIT_W = 4;

endpackage

// File: rtl/pwr_seq_regs.sv
// Control/config register file and registered read mux.
// Assumes: byte addresses 0x0 (control) and 0x4 (config); status inputs are read-only.
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [3:0]  RST_REST = 4'd2,
    parameter logic [3:0]  RST_FEW  = 4'd8,
    parameter logic [3:0]  RST_CLK  = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic              status_on,
    input  logic              up_done,
    input  logic              dn_done,
    output logic              col_q,
    output logic              hw_q,
    output logic              ovr_q,
    output logic [WAIT_W-1:0] w_rest,
    output logic [WAIT_W-1:0] w_few,
    output logic [WAIT_W-1:0] w_clk,
    output logic              retain_q,
    output logic [31:0]       rd_data
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4);

    logic [31:0] ctrl_word;
    logic [31:0] cfg_word;

    // Register writes; status bits are not stored here and so ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= 1'b1;
            hw_q     <= 1'b0;
            ovr_q    <= 1'b0;
            w_rest   <= RST_REST;
            w_few    <= RST_FEW;
            w_clk    <= RST_CLK;
            retain_q <= 1'b0;
        end else if (we) begin
            if (addr == A_CTRL) begin
                col_q  <= wdata[0];
                hw_q   <= wdata[1];
                ovr_q  <= wdata[2];
                w_clk  <= wdata[15:12];
                w_few  <= wdata[19:16];
                w_rest <= wdata[23:20];
            end else if (addr == A_CFG) begin
                retain_q <= wdata[11];
            end
        end
    end

    // Assemble the two readable words.
    always_comb begin
        ctrl_word = {status_on, 7'b0, w_rest, w_few, w_clk, 9'b0, ovr_q, hw_q, col_q};
        cfg_word  = {15'b0, up_done, dn_done, 3'b0, retain_q, 11'b0};
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_data <= '0;
        else if (addr == A_CTRL) rd_data <= ctrl_word;
        else if (addr == A_CFG)  rd_data <= cfg_word;
        else                     rd_data <= '0;
    end

endmodule

// File: rtl/pwr_seq_fsm.sv
// Switch sequencer: walks few-switch, rest-switch, clock-hold and clock-gate steps.
// Assumes: wait fields stay constant while a wait is running.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              req_off,
    input  logic              ovr,
    input  logic [WAIT_W-1:0] w_rest,
    input  logic [WAIT_W-1:0] w_few,
    input  logic [WAIT_W-1:0] w_clk,
    output seq_state_e        state,
    output logic              accept,
    output logic              sw_few_en,
    output logic              sw_rest_en,
    output logic              clk_en,
    output logic              up_done,
    output logic              dn_done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             step_ok;
    logic             done;
    seq_state_e       nxt_wait;

    // Limit and successor for the current wait step.
    always_comb begin
        lim      = '0;
        nxt_wait = S_OFF;
        unique case (state)
            S_FEW:    begin lim = (CNT_W'(1) << w_few)  - CNT_W'(1); nxt_wait = S_REST;  end
            S_REST:   begin lim = (CNT_W'(1) << w_rest) - CNT_W'(1); nxt_wait = S_HOLD;  end
            S_HOLD:   begin lim = CNT_W'(HOLD_CYC - 1);              nxt_wait = S_ON;    end
            S_CLKOFF: begin lim = (CNT_W'(1) << w_clk)  - CNT_W'(1); nxt_wait = S_OFF;   end
            default:  begin lim = '0;                                nxt_wait = S_OFF;   end
        endcase
        step_ok = (state == S_HOLD) ? 1'b1 : ref_tick;
        done    = ovr || (step_ok && (cnt == lim));
        accept  = ((state == S_OFF) && !req_off) || ((state == S_ON) && req_off);
    end

    // State and wait counter; requests are only sampled in stable states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_OFF;
            cnt   <= '0;
        end else begin
            unique case (state)
                S_OFF: if (!req_off) begin state <= S_FEW;    cnt <= '0; end
                S_ON:  if (req_off)  begin state <= S_CLKOFF; cnt <= '0; end
                default: begin
                    if (done) begin
                        state <= nxt_wait;
                        cnt   <= '0;
                    end else if (step_ok) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Output decode per state.
    always_comb begin
        sw_few_en  = (state != S_OFF);
        sw_rest_en = (state == S_REST) || (state == S_HOLD) || (state == S_ON) || (state == S_CLKOFF);
        clk_en     = (state == S_ON);
        up_done    = (state == S_ON);
        dn_done    = (state == S_OFF);
    end

    a_r5_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != S_OFF) && (state != S_ON)) |-> (cnt <= lim));

    a_r10_no_abort_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FEW) |=> ((state == S_FEW) || (state == S_REST)));

    a_r10_no_abort_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLKOFF) |=> ((state == S_CLKOFF) || (state == S_OFF)));

endmodule

// File: rtl/pwr_seq_lag.sv
// Power-on status with a fixed lag: frozen for LAG_TICKS reference ticks after each accepted request.
// Assumes: accept is a single-clock pulse from the sequencer.
module pwr_seq_lag #(
    parameter int LAG_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic accept,
    input  logic dom_on,
    output logic status_on
);
    localparam int LAG_W = $clog2(LAG_TICKS + 1);

    logic [LAG_W-1:0] lag;

    // Load, count down on ticks, and sample the domain state once the lag ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag       <= '0;
            status_on <= 1'b0;
        end else if (accept) begin
            lag <= LAG_W'(LAG_TICKS);
        end else if (lag != '0) begin
            if (ref_tick) lag <= lag - LAG_W'(1);
        end else begin
            status_on <= dom_on;
        end
    end

    a_r8_frozen_during_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (lag != '0) |=> $stable(status_on));

    a_r8_rise_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_on) |-> dom_on);

endmodule

// File: rtl/pwr_switch_seq.sv
// Top: register port, switch sequencer and lagged status for one power domain.
// Assumes: ref_tick and hw_trig are synchronous to clk.
module pwr_switch_seq
    import pwr_seq_pkg::*;
#(
    parameter int         ADDR_W    = 4,
    parameter int         CNT_W     = 16,
    parameter int         HOLD_CYC  = 4,
    parameter int         LAG_TICKS = 8,
    parameter logic [3:0] RST_REST  = 4'd2,
    parameter logic [3:0] RST_FEW   = 4'd8,
    parameter logic [3:0] RST_CLK   = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              hw_trig,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic              sw_few_en,
    output logic              sw_rest_en,
    output logic              clk_en,
    output logic              retain_en
);
    logic              col_q, hw_q, ovr_q, retain_q;
    logic [WAIT_W-1:0] w_rest, w_few, w_clk;
    logic              status_on, up_done, dn_done, accept, req_off;
    seq_state_e        state;

    // Effective request: trigger pin in hardware mode, collapse bit otherwise.
    always_comb req_off = hw_q ? hw_trig : col_q;

    // Retention enable straight from its config bit.
    always_comb retain_en = retain_q;

    pwr_seq_regs #(
        .ADDR_W(ADDR_W), .RST_REST(RST_REST), .RST_FEW(RST_FEW), .RST_CLK(RST_CLK)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .status_on(status_on), .up_done(up_done), .dn_done(dn_done),
        .col_q(col_q), .hw_q(hw_q), .ovr_q(ovr_q),
        .w_rest(w_rest), .w_few(w_few), .w_clk(w_clk),
        .retain_q(retain_q), .rd_data(rd_data)
    );

    pwr_seq_fsm #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .req_off(req_off), .ovr(ovr_q),
        .w_rest(w_rest), .w_few(w_few), .w_clk(w_clk),
        .state(state), .accept(accept),
        .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en), .clk_en(clk_en),
        .up_done(up_done), .dn_done(dn_done)
    );

    pwr_seq_lag #(.LAG_TICKS(LAG_TICKS)) lag_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .accept(accept),
        .dom_on(up_done), .status_on(status_on)
    );

    a_r3_few_before_rest: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_rest_en) |-> $past(sw_few_en));

    a_r4_gate_before_open: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_few_en) |-> $past(!clk_en));

    a_r4_gate_first_on_collapse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> sw_rest_en);

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clk_en, !sw_few_en}));

endmodule

// File: tb/pwr_switch_seq_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module pwr_switch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        hw_trig = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        sw_few_en, sw_rest_en, clk_en, retain_en;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    tick_mode = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    pwr_switch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hw_trig(hw_trig),
        .addr(addr), .we(we), .wdata(wdata), .rd_data(rd_data),
        .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en), .clk_en(clk_en), .retain_en(retain_en)
    );

    // Reference-tick pattern: every clock, or one clock in three.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        ref_tick <= (tick_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    // Behavioural model. Phases: 0 off, 1 few, 2 rest, 3 hold, 4 on, 5 clock-off.
    int   m_ph, m_rem, m_lag, m_wr, m_wf, m_wc, oph;
    bit   m_st, m_col, m_hw, m_ovr, m_ret, roff, acc;
    logic [31:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_lag = 0; m_st = 0;
            m_col = 1; m_hw = 0; m_ovr = 0; m_ret = 0;
            m_wr = 2; m_wf = 8; m_wc = 2; m_rd = '0;
        end else begin
            roff = m_hw ? hw_trig : m_col;
            acc = 0;
            oph = m_ph;
            if (addr == 4'h0)
                m_rd = {m_st, 7'b0, 4'(m_wr), 4'(m_wf), 4'(m_wc), 9'b0, m_ovr, m_hw, m_col};
            else if (addr == 4'h4)
                m_rd = {15'b0, oph == 4, oph == 0, 3'b0, m_ret, 11'b0};
            else
                m_rd = '0;
            if (m_ph == 0) begin
                if (!roff) begin m_ph = 1; m_rem = 1 << m_wf; acc = 1; end
            end else if (m_ph == 4) begin
                if (roff) begin m_ph = 5; m_rem = 1 << m_wc; acc = 1; end
            end else begin
                bit adv;
                adv = 0;
                if (m_ovr) adv = 1;
                else if (m_ph == 3 || ref_tick) begin
                    m_rem = m_rem - 1;
                    if (m_rem == 0) adv = 1;
                end
                if (adv) begin
                    if (m_ph == 1)      begin m_ph = 2; m_rem = 1 << m_wr; end
                    else if (m_ph == 2) begin m_ph = 3; m_rem = 4; end
                    else if (m_ph == 3) m_ph = 4;
                    else                m_ph = 0;
                end
            end
            if (acc) m_lag = 8;
            else if (m_lag > 0) begin
                if (ref_tick) m_lag = m_lag - 1;
            end else m_st = (oph == 4);
            if (we) begin
                if (addr == 4'h0) begin
                    m_col = wdata[0]; m_hw = wdata[1]; m_ovr = wdata[2];
                    m_wc = int'(wdata[15:12]); m_wf = int'(wdata[19:16]); m_wr = int'(wdata[23:20]);
                end else if (addr == 4'h4) m_ret = wdata[11];
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] e_bits, a_bits;
            e_bits = {m_ph >= 1, m_ph >= 2, m_ph == 4, m_ret};
            a_bits = {sw_few_en, sw_rest_en, clk_en, retain_en};
            checks++;
            if (e_bits !== a_bits || rd_data !== m_rd) begin
                failures++;
                $display("FAIL %s model cycle %0d: pins=%b rd=%h expected pins=%b rd=%h",
                         tag, cyc, a_bits, rd_data, e_bits, m_rd);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        step(1);
        we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit seen;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        step(1);
        check("R1 ctrl reset", rd_data, 32'h0028_2001);
        check("R1 pins off", {31'b0, sw_few_en | sw_rest_en | clk_en}, 32'h0);
        addr = 4'h4; step(1);
        check("R1 cfg reset", rd_data, 32'h0000_8000);

        // R2: read-only bits ignore writes, retain bit drives pin
        tag = "R2";
        wr(4'h0, 32'h8011_1001); step(1);
        check("R2 ctrl bit31 ignored", rd_data, 32'h0011_1001);
        wr(4'h4, 32'hFFFF_FFFF); step(1);
        check("R2 cfg flags ignored", rd_data, 32'h0000_8800);
        check("R2 retain pin", {31'b0, retain_en}, 32'h1);

        // R3 and R8: restore sequence and status lag
        tag = "R3";
        wr(4'h0, 32'h0011_1000);
        step(1);
        check("R3 few first", {30'b0, sw_few_en, sw_rest_en}, 32'h2);
        step(2);
        check("R3 rest after 2 ticks", {30'b0, sw_rest_en, clk_en}, 32'h2);
        step(5);
        check("R3 clocks held", {31'b0, clk_en}, 32'h0);
        step(1);
        check("R3 clocks released", {31'b0, clk_en}, 32'h1);
        tag = "R8";
        step(1);
        check("R8 status still lagging", {31'b0, rd_data[31]}, 32'h0);
        step(1);
        check("R8 status on after lag", {31'b0, rd_data[31]}, 32'h1);
        tag = "R9";
        addr = 4'h4; step(1);
        check("R9 up-complete flag", rd_data, 32'h0001_0800);

        // R4: collapse
        tag = "R4";
        wr(4'h0, 32'h0011_1001);
        step(1);
        check("R4 clock gated first", {30'b0, clk_en, sw_few_en}, 32'h1);
        step(2);
        check("R4 switches open", {30'b0, sw_few_en, sw_rest_en}, 32'h0);
        step(12);
        addr = 4'h4; step(1);
        check("R9 down-complete flag", rd_data, 32'h0000_8800);

        // R5: sparse reference ticks
        tag = "R5";
        tick_mode = 1;
        wr(4'h0, 32'h0012_2000);
        step(14);
        check("R5 still sequencing on sparse ticks", {31'b0, clk_en}, 32'h0);
        step(66);
        check("R5 reached on", {31'b0, clk_en}, 32'h1);
        wr(4'h0, 32'h0012_2001);
        step(40);
        check("R5 reached off", {31'b0, sw_few_en}, 32'h0);
        tick_mode = 0;
        step(2);

        // R6: software override skips waits
        tag = "R6";
        wr(4'h0, 32'h00FF_F004);
        step(3);
        check("R6 hold one clock", {31'b0, clk_en}, 32'h0);
        step(1);
        check("R6 on after four clocks", {31'b0, clk_en}, 32'h1);
        wr(4'h0, 32'h00FF_F005);
        step(2);
        check("R6 off after two clocks", {31'b0, sw_few_en}, 32'h0);
        step(12);

        // R7: hardware trigger replaces collapse bit
        tag = "R7";
        hw_trig = 1'b1;
        wr(4'h0, 32'h0000_0002);
        step(20);
        check("R7 collapse bit ignored", {31'b0, sw_few_en}, 32'h0);
        hw_trig = 1'b0;
        step(20);
        check("R7 trigger restores", {31'b0, clk_en}, 32'h1);
        wr(4'h0, 32'h0000_0003);
        step(20);
        check("R7 collapse bit ignored while on", {31'b0, clk_en}, 32'h1);
        hw_trig = 1'b1;
        step(20);
        check("R7 trigger collapses", {31'b0, sw_few_en}, 32'h0);
        wr(4'h0, 32'h0000_0001);
        step(5);

        // R10: mid-sequence request deferred
        tag = "R10";
        wr(4'h0, 32'h0003_0000);
        step(2);
        wr(4'h0, 32'h0003_0001);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (clk_en) seen = 1;
            step(1);
        end
        check("R10 sequence completed before collapse", {31'b0, seen}, 32'h1);
        step(10);
        check("R10 collapsed afterwards", {31'b0, sw_few_en}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule